// File: doc/BRIEF.md
# Serial Attenuator Chain Write Master

This block programs a daisy chain of serial-controlled audio attenuators from the host side. A single start pulse captures one channel-address byte and one attenuation-code byte for each device in the chain. The block then drives three wires: an active-low load enable, a serial clock and a serial data line. It sends every frame in one enable window and then releases the enable, which latches all devices at the same moment.

Each device's shift register passes older bits on to the next device. For that reason the frame for the device farthest from the host leaves first and the frame for the nearest device leaves last. Every timing value is a parameter counted in system-clock cycles. The defaults suit a 250 MHz system clock: the serial clock stays below 2 MHz and the enable leads the first clock edge by more than 150 ns. The block reports `busy` while a write is in progress and gives a one-cycle `done` pulse when the write is finished.

Top module: `chain_atten_writer`

## Requirements
- R1: After reset and whenever idle, `ser_en_n` is 1, `ser_clk` is 0, `ser_data` is 0, and `busy` and `done` are 0.
- R2: After an accepted start, `ser_en_n` falls on the next clock edge and stays low for exactly SETUP_CYC cycles before the first rising edge of `ser_clk`.
- R3: Every high phase and every low phase of `ser_clk` between rising edges lasts exactly HALF_CYC system cycles.
- R4: `ser_clk` is high only while `ser_en_n` is low, and one enable window contains exactly 16×N_DEV rising edges (N_DEV × (ADDR_W+CODE_W)).
- R5: `ser_data` changes only while `ser_clk` is low. It is stable in the cycle of each rising edge and for the whole high phase.
- R6: The bit order is fixed. Device slot N_DEV-1 (bits `[k*8 +: 8]` of each bus for slot k) is sent first and slot 0 last. Within each frame the address byte comes before the code byte, and each byte is sent MSB first.
- R7: `ser_en_n` returns high exactly HALF_CYC cycles after the last falling edge of `ser_clk`, with `ser_clk` low.
- R8: `done` is high for exactly one cycle, the cycle after `ser_en_n` returns high. `busy` is 1 from the cycle after an accepted start until that cycle, where it drops to 0.
- R9: A start pulse while `busy` is 1 is ignored. No second enable window opens, only one `done` occurs, and the serial stream carries the data captured at the first start.
- R10: The address and code buses are captured at the accepted start. Changes to them during a write do not alter the serial stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a chain write; only honoured while not busy |
| dev_addr | input | N_DEV*ADDR_W | Channel address per device slot, slot 0 nearest the host |
| dev_code | input | N_DEV*CODE_W | Attenuation code per device slot |
| ser_clk | output | 1 | Serial clock to the chain |
| ser_en_n | output | 1 | Active-low load/shift enable to the chain |
| ser_data | output | 1 | Serial data to the first device |
| busy | output | 1 | Write in progress |
| done | output | 1 | One-cycle pulse after the enable is released |

## Verification
The assertions assume that SETUP_CYC and HALF_CYC are at least one. They also assume that `start` is sampled only on the rising clock edge, so a start can land in any state, including the final cycle of a write. Beyond that they ask nothing of the data buses, which may change at any time. The stimulus changes all inputs half a cycle away from the active edge. It deliberately raises `start` and rewrites both buses in the middle of a write, so that the ignore and capture rules are exercised rather than assumed.

// File: rtl/chain_wr_pkg.sv
package chain_wr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HIGH,
    ST_LOW,
    ST_TAIL,
    ST_FIN
  } cw_state_e;

  function automatic int cw_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cw_frame_packer.sv
module cw_frame_packer #(
  parameter int N_DEV  = 3,
  parameter int ADDR_W = 8,
  parameter int CODE_W = 8
) (
  input  logic [N_DEV*ADDR_W-1:0]          addr_bus,
  input  logic [N_DEV*CODE_W-1:0]          code_bus,
  output logic [N_DEV*(ADDR_W+CODE_W)-1:0] stream
);
  localparam int FRAME_W = ADDR_W + CODE_W;

  // Slot k sits at stream slice k; the top slice (farthest device) leaves first.
  for (genvar k = 0; k < N_DEV; k++) begin : g_slot
    assign stream[k*FRAME_W +: FRAME_W] =
      {addr_bus[k*ADDR_W +: ADDR_W], code_bus[k*CODE_W +: CODE_W]};
  end
endmodule

// File: rtl/cw_phase_timer.sv
module cw_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (load)      cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/cw_bit_shifter.sv
module cw_bit_shifter #(
  parameter int WIDTH = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  input  logic             shift,
  input  logic             clear,
  output logic             msb,
  output logic             last
);
  localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  logic [WIDTH-1:0] sreg;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      sreg <= '0;
      idx  <= '0;
    end else if (load) begin
      sreg <= load_val;
      idx  <= '0;
    end else if (shift) begin
      sreg <= {sreg[WIDTH-2:0], 1'b0};
      idx  <= idx + 1'b1;
    end
  end

  assign msb  = sreg[WIDTH-1];
  assign last = (idx == IDX_W'(WIDTH-1));

  // R4: never shift past the final bit of the window
  p_no_overrun_r4: assert property (@(posedge clk) disable iff (rst)
    shift |-> !last);
endmodule

// File: rtl/chain_atten_writer.sv
module chain_atten_writer
  import chain_wr_pkg::*;
#(
  parameter int N_DEV     = 3,
  parameter int ADDR_W    = 8,
  parameter int CODE_W    = 8,
  parameter int HALF_CYC  = 63,
  parameter int SETUP_CYC = 38
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [N_DEV*ADDR_W-1:0] dev_addr,
  input  logic [N_DEV*CODE_W-1:0] dev_code,
  output logic                    ser_clk,
  output logic                    ser_en_n,
  output logic                    ser_data,
  output logic                    busy,
  output logic                    done
);
  localparam int FRAME_W  = ADDR_W + CODE_W;
  localparam int STREAM_W = N_DEV * FRAME_W;
  localparam int TMR_MAX  = cw_max(HALF_CYC, SETUP_CYC);
  localparam int TMR_W    = $clog2(TMR_MAX + 1);

  cw_state_e          state;
  logic [STREAM_W-1:0] stream;
  logic               tmr_load;
  logic [TMR_W-1:0]   tmr_val;
  logic               tmr_zero;
  logic               sh_load;
  logic               sh_shift;
  logic               sh_clear;
  logic               sh_last;

  cw_frame_packer #(.N_DEV(N_DEV), .ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_pack (
    .addr_bus (dev_addr),
    .code_bus (dev_code),
    .stream   (stream)
  );

  cw_phase_timer #(.CNT_W(TMR_W)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_zero)
  );

  cw_bit_shifter #(.WIDTH(STREAM_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .load     (sh_load),
    .load_val (stream),
    .shift    (sh_shift),
    .clear    (sh_clear),
    .msb      (ser_data),
    .last     (sh_last)
  );

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = TMR_W'(HALF_CYC - 1);
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    sh_clear = 1'b0;
    unique case (state)
      ST_IDLE: if (start) begin
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(SETUP_CYC - 1);
        sh_load  = 1'b1;
      end
      ST_SETUP: tmr_load = tmr_zero;
      ST_HIGH: begin
        tmr_load = tmr_zero;
        sh_shift = tmr_zero && !sh_last;
      end
      ST_LOW:  tmr_load = tmr_zero;
      ST_TAIL: tmr_load = 1'b0;
      ST_FIN:  sh_clear = 1'b1;
      default: tmr_load = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      ser_clk  <= 1'b0;
      ser_en_n <= 1'b1;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          ser_en_n <= 1'b0;
          busy     <= 1'b1;
          state    <= ST_SETUP;
        end
        ST_SETUP: if (tmr_zero) begin
          ser_clk <= 1'b1;
          state   <= ST_HIGH;
        end
        ST_HIGH: if (tmr_zero) begin
          ser_clk <= 1'b0;
          state   <= sh_last ? ST_TAIL : ST_LOW;
        end
        ST_LOW: if (tmr_zero) begin
          ser_clk <= 1'b1;
          state   <= ST_HIGH;
        end
        ST_TAIL: if (tmr_zero) begin
          ser_en_n <= 1'b1;
          state    <= ST_FIN;
        end
        ST_FIN: begin
          busy  <= 1'b0;
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  logic [31:0] hi_run;
  logic [31:0] setup_run;
  logic        clk_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_run    <= '0;
      setup_run <= '0;
      clk_seen  <= 1'b0;
    end else begin
      hi_run <= ser_clk ? hi_run + 1 : '0;
      if (ser_en_n) begin
        setup_run <= '0;
        clk_seen  <= 1'b0;
      end else begin
        if (!clk_seen && !ser_clk) setup_run <= setup_run + 1;
        if (ser_clk) clk_seen <= 1'b1;
      end
    end
  end

  // R2: enable leads the first clock edge by SETUP_CYC cycles
  p_setup_lead_r2: assert property (@(posedge clk) disable iff (rst)
    ($rose(ser_clk) && !clk_seen) |-> (setup_run == 32'(SETUP_CYC)));

  // R3: each high phase spans HALF_CYC cycles
  p_high_width_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(ser_clk) |-> (hi_run == 32'(HALF_CYC)));

  // R4: clock pulses only inside the enable window
  p_clk_in_window_r4: assert property (@(posedge clk) disable iff (rst)
    ser_clk |-> !ser_en_n);

  // R5: data steady while the clock is high
  p_data_steady_r5: assert property (@(posedge clk) disable iff (rst)
    ser_clk |-> $stable(ser_data));

  // R7: release happens with the clock parked low
  p_release_low_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_en_n) |-> (!ser_clk && !$past(ser_clk)));

  // R8: done is a single pulse after release
  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_after_release_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> (ser_en_n && !busy && $past(busy)));

  // R9: start during a write never reopens the window
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> !$fell(ser_en_n));
endmodule

// File: tb/tb_chain_atten_writer.sv
module tb_chain_atten_writer;
  localparam int N_DEV     = 3;
  localparam int ADDR_W    = 8;
  localparam int CODE_W    = 8;
  localparam int HALF_CYC  = 63;
  localparam int SETUP_CYC = 38;
  localparam int FRAME_W   = ADDR_W + CODE_W;
  localparam int STREAM_W  = N_DEV * FRAME_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [N_DEV*ADDR_W-1:0] dev_addr = '0;
  logic [N_DEV*CODE_W-1:0] dev_code = '0;
  logic ser_clk, ser_en_n, ser_data, busy, done;

  always #2 clk = ~clk;

  chain_atten_writer #(
    .N_DEV(N_DEV), .ADDR_W(ADDR_W), .CODE_W(CODE_W),
    .HALF_CYC(HALF_CYC), .SETUP_CYC(SETUP_CYC)
  ) dut (
    .clk(clk), .rst(rst), .start(start), .dev_addr(dev_addr), .dev_code(dev_code),
    .ser_clk(ser_clk), .ser_en_n(ser_en_n), .ser_data(ser_data),
    .busy(busy), .done(done)
  );

  int n_checks = 0;
  int n_fail   = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // ---------------- negedge monitor ----------------
  int  cyc = 0;
  int  le_fall_c, first_rise_c, last_rise_c, last_fall_c, le_rise_c, done_c;
  int  rises, bad_hi, bad_lo, data_moves, clk_outside, done_cnt, le_falls;
  logic cap [0:STREAM_W-1];
  logic p_sclk = 1'b0, p_le = 1'b1, p_sdo = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (!ser_en_n && p_le) begin
        le_fall_c = cyc; rises = 0; bad_hi = 0; bad_lo = 0;
        data_moves = 0; clk_outside = 0; le_falls++;
      end
      if (ser_clk && !p_sclk) begin
        if (rises == 0) first_rise_c = cyc;
        else if (cyc - last_fall_c != HALF_CYC) bad_lo++;
        if (rises < STREAM_W) cap[rises] = ser_data;
        rises++;
        last_rise_c = cyc;
        if (ser_data != p_sdo) data_moves++;
      end
      if (!ser_clk && p_sclk) begin
        if (cyc - last_rise_c != HALF_CYC) bad_hi++;
        last_fall_c = cyc;
      end
      if (ser_clk && p_sclk && ser_data != p_sdo) data_moves++;
      if (ser_clk && ser_en_n) clk_outside++;
      if (ser_en_n && !p_le) le_rise_c = cyc;
      if (done) begin done_cnt++; done_c = cyc; end
    end
    p_sclk = ser_clk; p_le = ser_en_n; p_sdo = ser_data;
    cyc++;
  end

  function automatic logic exp_bit(input int k,
                                   input logic [N_DEV*ADDR_W-1:0] a,
                                   input logic [N_DEV*CODE_W-1:0] c);
    int dev = N_DEV - 1 - k / FRAME_W;
    int j   = k % FRAME_W;
    if (j < ADDR_W) return a[dev*ADDR_W + ADDR_W - 1 - j];
    return c[dev*CODE_W + FRAME_W - 1 - j];
  endfunction

  task automatic check_idle(input string tag);
    check(ser_en_n == 1'b1, {tag, " R1 en_n"}, ser_en_n, 1);
    check(ser_clk  == 1'b0, {tag, " R1 sclk"}, ser_clk, 0);
    check(ser_data == 1'b0, {tag, " R1 data"}, ser_data, 0);
    check(busy     == 1'b0, {tag, " R1 busy"}, busy, 0);
    check(done     == 1'b0, {tag, " R1 done"}, done, 0);
  endtask

  // mode: 0 plain, 1 retrigger start mid-write (R9), 2 rewrite buses mid-write (R10)
  task automatic run_write(input logic [N_DEV*ADDR_W-1:0] a,
                           input logic [N_DEV*CODE_W-1:0] c,
                           input int mode, input string tag);
    int wait_c;
    int mism;
    done_cnt = 0; le_falls = 0;
    @(negedge clk);
    dev_addr = a; dev_code = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, {tag, " R8 busy after start"}, busy, 1);
    if (mode == 1) begin
      repeat (300) @(negedge clk);
      dev_addr = ~a; dev_code = ~c; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end else if (mode == 2) begin
      repeat (500) @(negedge clk);
      dev_addr = ~a; dev_code = ~c;
    end
    wait_c = 0;
    while (!done && wait_c < 20000) begin
      @(negedge clk);
      wait_c++;
    end
    repeat (8) @(negedge clk);
    check(first_rise_c - le_fall_c == SETUP_CYC, {tag, " R2 setup"},
          first_rise_c - le_fall_c, SETUP_CYC);
    check(bad_hi == 0 && bad_lo == 0, {tag, " R3 phase widths"}, bad_hi + bad_lo, 0);
    check(rises == STREAM_W, {tag, " R4 edge count"}, rises, STREAM_W);
    check(clk_outside == 0, {tag, " R4 clock outside window"}, clk_outside, 0);
    check(data_moves == 0, {tag, " R5 data move at/in high"}, data_moves, 0);
    mism = 0;
    for (int k = 0; k < STREAM_W; k++)
      if (cap[k] !== exp_bit(k, a, c)) mism++;
    check(mism == 0, {tag, (mode == 2) ? " R10 captured stream" : " R6 bit order"}, mism, 0);
    check(le_rise_c - last_fall_c == HALF_CYC, {tag, " R7 release delay"},
          le_rise_c - last_fall_c, HALF_CYC);
    check(done_c == le_rise_c + 1, {tag, " R8 done timing"}, done_c - le_rise_c, 1);
    check(done_cnt == 1, {tag, " R8 done count"}, done_cnt, 1);
    if (mode == 1)
      check(le_falls == 1, {tag, " R9 single window"}, le_falls, 1);
    check_idle(tag);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_idle("reset");
    run_write({8'h02, 8'h01, 8'h00}, {8'h7F, 8'h00, 8'hA5}, 0, "pattern_a");
    run_write({8'hFF, 8'h55, 8'h80}, {8'h01, 8'hAA, 8'hFE}, 0, "pattern_b");
    run_write({8'h01, 8'h02, 8'h00}, {8'h3C, 8'h5F, 8'h60}, 1, "retrigger");
    run_write({8'h00, 8'h01, 8'h02}, {8'h12, 8'h34, 8'h56}, 2, "bus_change");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule